// File: doc/BRIEF.md
# Reloadable Time-Multiplexed FIR Filter

This block is an FIR filter with a fixed tap count, built around a single hardware multiplier that is shared over time. The coefficient values are not fixed when the design is built. After every reset, and again whenever a reload is requested, a load sequencer copies the whole coefficient set out of an external memory into an internal register file. It reads that memory through a simple synchronous port that has one cycle of read latency. Once the set is stored, the filter accepts signed samples through a valid/ready handshake. It spends one clock per multiply to build each output sample in a full-width accumulator, with no rounding and no saturation.

A build-time option selects symmetric operation. In that mode the two samples that share a coefficient are summed before the multiply, so only ceil(N/2) multiply cycles are needed per output. For odd N the centre tap is multiplied once on its own. Samples sit in a circular buffer whose write pointer moves by one for each accepted sample. That history is cleared only by reset, and it survives a coefficient reload.

Top module: `fir_serial_mac`

## Requirements
- R1: Each load drives `coef_rd_en` high for exactly N consecutive cycles with `coef_addr` equal to 0, 1, …, N-1 in order. The first of those cycles directly follows reset release, or the cycle in which the load begins. The word for an address is taken from `coef_rd_data` one cycle after that address is presented.
- R2: During reset, `coef_ready`, `in_ready` and `out_valid` are low. `coef_ready` goes high N+1 cycles after the first address cycle of a load. While it is low, `in_ready` and `out_valid` stay low.
- R3: With symmetric mode off, every output equals the sum over k = 0…N-1 of c[k]·x[n-k]. Here c[k] is the word loaded from address k, x[n] is the sample just accepted, and samples from before the last reset count as 0.
- R4: `out_valid` is high for exactly one cycle, S clock edges after the edge that accepts a sample. S = N with symmetric mode off and S = ceil(N/2) with it on. No output carries any part of an earlier output's sum.
- R5: `in_ready` is high during the final multiply cycle of an output, so with `in_valid` held high, successive samples are accepted exactly S cycles apart.
- R6: A `reload_req` pulse that arrives while an output is being computed does not disturb that output, which still uses the old coefficients. The load's first address cycle is the cycle right after that output's `out_valid` cycle, and no sample is accepted between the request and the end of the load.
- R7: With symmetric mode on, each output equals the sum over s < ceil(N/2) of c[s]·(x[n-s] + x[n-(N-1-s)]). When N is odd, the centre index s = (N-1)/2 contributes c[s]·x[n-s] once.
- R8: A coefficient reload leaves the sample history unchanged. The first outputs after a reload combine the new coefficients with samples accepted before it.
- R9: The output is the complete accumulator, with OPW+CW+ceil(log2 N) bits, where OPW = DW (or DW+1 in symmetric mode). The largest-magnitude positive and negative results are returned exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a coefficient load when released |
| reload_req | input | 1 | One-cycle request to fetch the coefficient set again |
| coef_rd_en | output | 1 | Read strobe to the external coefficient memory |
| coef_addr | output | AW | Coefficient memory address |
| coef_rd_data | input | CW | Signed coefficient word, valid one cycle after its address |
| coef_ready | output | 1 | Coefficient set complete; filtering enabled |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a finished output |
| out_data | output | ACCW | Signed full-precision filter output |

## Verification
Each result has a fixed due cycle. The load's first address appears in the cycle after reset release. `coef_ready` rises N+1 edges after that. An output comes S edges after the accepting edge. A reload that was held back shows its first address one cycle after the held output's strobe. The bench samples every signal on the falling clock edge. When it sees a handshake, it computes the expected value and stores it in a queue together with its due cycle, which is the current cycle count plus 1 + S. A strobe that arrives early, late or not at all therefore fails on timing, even if the data would match. Two filters run side by side: eight taps without symmetry, and seven symmetric taps so that the centre-tap case is exercised.

// File: rtl/fir_pkg.sv
// Shared definitions for the time-multiplexed FIR filter.
package fir_pkg;

    // Coefficient loader phases: issuing addresses, waiting for the last word, idle.
    typedef enum logic [1:0] {
        LD_ISSUE = 2'd0,
        LD_DRAIN = 2'd1,
        LD_DONE  = 2'd2
    } load_state_e;

    // Multiply cycles needed per output for a given tap count and mode.
    function automatic int mac_steps(input int taps, input bit sym);
        return sym ? (taps + 1) / 2 : taps;
    endfunction

endpackage

// File: rtl/fir_coef_store.sv
// Coefficient load sequencer plus register file.
// Presents addresses 0..NTAPS-1 on consecutive cycles and stores the word
// that returns one cycle later. Asserts ready once the last word is written.
// Assumes the external memory has exactly one cycle of read latency and
// that load_start is raised only while ready is high.
module fir_coef_store
    import fir_pkg::*;
#(
    parameter int NTAPS = 8,
    parameter int CW    = 16,
    parameter int AW    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_start,
    output logic                 rd_en,
    output logic [AW-1:0]        rd_addr,
    input  logic signed [CW-1:0] rd_data,
    output logic                 ready,
    input  logic [AW-1:0]        sel_idx,
    output logic signed [CW-1:0] sel_coef
);

    load_state_e          state;
    logic [AW-1:0]        issue_cnt;
    logic                 pend_valid;
    logic [AW-1:0]        pend_idx;
    logic signed [CW-1:0] coef_q [NTAPS];

    // Address sequencing and load phase tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LD_ISSUE;
            issue_cnt <= '0;
        end else if (load_start) begin
            state     <= LD_ISSUE;
            issue_cnt <= '0;
        end else begin
            case (state)
                LD_ISSUE: begin
                    issue_cnt <= issue_cnt + 1'b1;
                    if (issue_cnt == AW'(NTAPS - 1))
                        state <= LD_DRAIN;
                end
                LD_DRAIN: state <= LD_DONE;
                default:  state <= LD_DONE;
            endcase
        end
    end

    // Remember which address is in flight so its data lands in the right slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_idx   <= '0;
        end else begin
            pend_valid <= rd_en;
            pend_idx   <= issue_cnt;
        end
    end

    // Register file write: one coefficient per cycle, one cycle behind its address.
    always_ff @(posedge clk) begin
        if (pend_valid)
            coef_q[pend_idx] <= rd_data;
    end

    // Outputs toward memory and toward the MAC.
    always_comb begin
        rd_en    = (state == LD_ISSUE);
        rd_addr  = issue_cnt;
        ready    = (state == LD_DONE);
        sel_coef = coef_q[sel_idx];
    end

endmodule

// File: rtl/fir_sample_ring.sv
// Circular sample history with a combinational tap operand.
// The write pointer moves by one slot per accepted sample; lag 0 is the newest.
// In symmetric mode the operand is the sum of the two samples that share
// coefficient 'step'; at the odd-length centre only one sample is used.
// Cleared only by reset, so history survives coefficient reloads.
module fir_sample_ring #(
    parameter int NTAPS = 8,
    parameter int DW    = 16,
    parameter int AW    = 3,
    parameter bit SYM   = 1'b0,
    parameter int OPW   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic signed [DW-1:0]  wr_data,
    input  logic [AW-1:0]         step,
    output logic signed [OPW-1:0] operand
);

    logic signed [DW-1:0] ring [NTAPS];
    logic [AW-1:0]        head;
    logic [AW-1:0]        head_nxt;

    // Slot index of the sample 'lag' positions older than the newest one.
    function automatic logic [AW-1:0] back(input logic [AW-1:0] h, input logic [AW-1:0] lag);
        if (h >= lag) return h - lag;
        return AW'(int'(h) + NTAPS - int'(lag));
    endfunction

    // Next write slot with wrap at NTAPS.
    always_comb head_nxt = (head == AW'(NTAPS - 1)) ? '0 : head + 1'b1;

    // History update on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            for (int i = 0; i < NTAPS; i++) ring[i] <= '0;
        end else if (wr_en) begin
            head           <= head_nxt;
            ring[head_nxt] <= wr_data;
        end
    end

    generate
        if (SYM) begin : g_sym
            logic [AW-1:0]        lag_b;
            logic signed [DW-1:0] smp_a;
            logic signed [DW-1:0] smp_b;
            // Pre-add of mirrored samples; centre tap passes alone.
            always_comb begin
                lag_b   = AW'(NTAPS - 1) - step;
                smp_a   = ring[back(head, step)];
                smp_b   = ring[back(head, lag_b)];
                operand = (lag_b == step) ? OPW'(smp_a) : OPW'(smp_a) + OPW'(smp_b);
            end
        end else begin : g_plain
            // Direct tap: one sample per coefficient.
            always_comb operand = OPW'(ring[back(head, step)]);
        end
    endgenerate

endmodule

// File: rtl/fir_mac_seq.sv
// Single-multiplier accumulate sequencer.
// 'start' clears the accumulator and begins STEPS multiply cycles; the final
// cycle writes the full sum to out_data and strobes out_valid for one clock.
// A start may coincide with the final cycle of the previous output.
module fir_mac_seq #(
    parameter int AW    = 3,
    parameter int OPW   = 16,
    parameter int CW    = 16,
    parameter int ACCW  = 35,
    parameter int STEPS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic signed [OPW-1:0]  operand,
    input  logic signed [CW-1:0]   coef,
    output logic [AW-1:0]          step,
    output logic                   busy,
    output logic                   last,
    output logic                   out_valid,
    output logic signed [ACCW-1:0] out_data
);

    localparam int PW = OPW + CW;

    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] sum;

    // The one multiplier and the adder that feeds the accumulator.
    always_comb begin
        prod = PW'(operand) * PW'(coef);
        sum  = acc + ACCW'(prod);
        last = busy && (step == AW'(STEPS - 1));
    end

    // Step counting, accumulation and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            step      <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= last;
            if (last)
                out_data <= sum;
            if (start) begin
                busy <= 1'b1;
                step <= '0;
                acc  <= '0;
            end else if (last) begin
                busy <= 1'b0;
            end else if (busy) begin
                step <= step + 1'b1;
                acc  <= sum;
            end
        end
    end

endmodule

// File: rtl/fir_serial_mac.sv
// Top level of the reloadable time-multiplexed FIR filter.
// Loads NTAPS coefficients after reset and on request, then filters a
// valid/ready sample stream with one multiplier. A reload request is held
// until any output in progress completes; inputs are refused meanwhile.
// Assumes NTAPS >= 2 and a one-cycle-latency coefficient memory.
module fir_serial_mac
    import fir_pkg::*;
#(
    parameter int NTAPS     = 8,
    parameter int DW        = 16,
    parameter int CW        = 16,
    parameter bit SYMMETRIC = 1'b0,
    localparam int AW       = (NTAPS > 1) ? $clog2(NTAPS) : 1,
    localparam int OPW      = SYMMETRIC ? DW + 1 : DW,
    localparam int ACCW     = OPW + CW + $clog2(NTAPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reload_req,
    output logic                   coef_rd_en,
    output logic [AW-1:0]          coef_addr,
    input  logic signed [CW-1:0]   coef_rd_data,
    output logic                   coef_ready,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic signed [DW-1:0]   in_data,
    output logic                   out_valid,
    output logic signed [ACCW-1:0] out_data
);

    localparam int STEPS = mac_steps(NTAPS, SYMMETRIC);

    logic                  reload_pend;
    logic                  load_start;
    logic                  accept;
    logic                  busy;
    logic                  last;
    logic [AW-1:0]         step;
    logic signed [CW-1:0]  cur_coef;
    logic signed [OPW-1:0] operand;

    // Handshake and reload gating.
    always_comb begin
        in_ready   = coef_ready && !reload_pend && (!busy || last);
        accept     = in_valid && in_ready;
        load_start = reload_pend && !busy;
    end

    // Hold a reload request until the MAC is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_pend <= 1'b0;
        else if (load_start)
            reload_pend <= 1'b0;
        else if (reload_req && coef_ready)
            reload_pend <= 1'b1;
    end

    fir_coef_store #(.NTAPS(NTAPS), .CW(CW), .AW(AW)) u_coef (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .rd_en      (coef_rd_en),
        .rd_addr    (coef_addr),
        .rd_data    (coef_rd_data),
        .ready      (coef_ready),
        .sel_idx    (step),
        .sel_coef   (cur_coef)
    );

    fir_sample_ring #(.NTAPS(NTAPS), .DW(DW), .AW(AW), .SYM(SYMMETRIC), .OPW(OPW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_data (in_data),
        .step    (step),
        .operand (operand)
    );

    fir_mac_seq #(.AW(AW), .OPW(OPW), .CW(CW), .ACCW(ACCW), .STEPS(STEPS)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .operand   (operand),
        .coef      (cur_coef),
        .step      (step),
        .busy      (busy),
        .last      (last),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fir_serial_mac_chk.sv
// Protocol checker for fir_serial_mac, attached by bind.
// Observes only top-level ports.
module fir_serial_mac_chk #(
    parameter int NTAPS     = 8,
    parameter bit SYMMETRIC = 1'b0,
    parameter int AW        = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          coef_rd_en,
    input logic [AW-1:0] coef_addr,
    input logic          coef_ready,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid
);

    localparam int S = SYMMETRIC ? (NTAPS + 1) / 2 : NTAPS;

    // R1: addresses advance by one on consecutive read cycles.
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        coef_rd_en && $past(coef_rd_en) && $past(rst_n) |-> coef_addr == $past(coef_addr) + 1'b1);

    // R1: the read burst ends on the last address.
    a_r1_last_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coef_rd_en) && $past(rst_n) |-> $past(coef_addr) == AW'(NTAPS - 1));

    // R2: nothing enters or leaves while the coefficient set is incomplete.
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_ready |-> !in_ready && !out_valid);

    // R6: a load begins only after a cycle in which no sample could be taken.
    a_r6_no_accept_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coef_ready) |-> !$past(in_ready));

    generate
        if (S > 1) begin : g_multi
            // R4: the output strobe lasts a single cycle.
            a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid);
            // R5: after an accept the filter is busy for at least one cycle.
            a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && in_ready |=> !in_ready);
        end
    endgenerate

endmodule

bind fir_serial_mac fir_serial_mac_chk #(
    .NTAPS(NTAPS), .SYMMETRIC(SYMMETRIC), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_rd_en (coef_rd_en),
    .coef_addr  (coef_addr),
    .coef_ready (coef_ready),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid)
);

// File: tb/sim_fir_serial_mac.sv
// Harness: one filter instance, its coefficient memory model, stimulus and scoreboard.
module fir_harness #(
    parameter int N    = 8,
    parameter bit SYM  = 1'b0,
    parameter int SEED = 1
) (
    input logic clk,
    input logic rst_n
);
    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int AW   = $clog2(N);
    localparam int OPW  = SYM ? DW + 1 : DW;
    localparam int ACCW = OPW + CW + $clog2(N);
    localparam int S    = SYM ? (N + 1) / 2 : N;

    logic                   reload_req, coef_rd_en, coef_ready, in_valid, in_ready, out_valid;
    logic [AW-1:0]          coef_addr;
    logic signed [CW-1:0]   coef_rd_data;
    logic signed [DW-1:0]   in_data;
    logic signed [ACCW-1:0] out_data;

    fir_serial_mac #(.NTAPS(N), .DW(DW), .CW(CW), .SYMMETRIC(SYM)) u0 (
        .clk(clk), .rst_n(rst_n), .reload_req(reload_req),
        .coef_rd_en(coef_rd_en), .coef_addr(coef_addr), .coef_rd_data(coef_rd_data),
        .coef_ready(coef_ready), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    int cyc   = 0;
    string  tag;
    logic signed [CW-1:0] cmem [N];
    longint hist [N];
    longint lc [N];
    longint exp_q [$];
    int     due_q [$];
    string  tag_q [$];
    int     acc_cyc;

    // Memory model with one cycle of read latency.
    always @(posedge clk) if (coef_rd_en) coef_rd_data <= cmem[coef_addr];
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s N=%0d sym=%0d cyc=%0d: actual %0d expected %0d", req, N, SYM, cyc, act, exp);
        end
    endtask

    // Expected output from the requirement equations (R3, R7).
    function automatic longint model();
        longint s = 0;
        for (int k = 0; k < S; k++) begin
            if (!SYM) s += lc[k] * hist[k];
            else if (N - 1 - k == k) s += lc[k] * hist[k];
            else s += lc[k] * (hist[k] + hist[N - 1 - k]);
        end
        return s;
    endfunction

    // Scoreboard, sampled on the falling edge.
    bit prev_en, prev_rdy;
    int ld_t0, last_addr;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_en = 0; prev_rdy = 0;
            for (int i = 0; i < N; i++) hist[i] = 0;
            exp_q.delete(); due_q.delete(); tag_q.delete();
        end else begin
            if (coef_rd_en) begin
                if (!prev_en) begin
                    ld_t0 = cyc;
                    chk(coef_addr == 0, "R1 first addr", coef_addr, 0);
                end else
                    chk(int'(coef_addr) == last_addr + 1, "R1 addr step", coef_addr, last_addr + 1);
                last_addr = coef_addr;
            end else if (prev_en)
                chk(last_addr == N - 1, "R1 burst length", last_addr, N - 1);
            prev_en = coef_rd_en;
            if (coef_ready && !prev_rdy) begin
                chk(cyc == ld_t0 + N + 1, "R2 ready timing", cyc - ld_t0, N + 1);
                for (int i = 0; i < N; i++) lc[i] = longint'(cmem[i]);
            end
            prev_rdy = coef_ready;
            if (!coef_ready)
                chk(!in_ready && !out_valid, "R2 gated while loading", {in_ready, out_valid}, 0);
            if (out_valid) begin
                if (due_q.size() == 0) chk(0, "R4 unexpected out_valid", 1, 0);
                else begin
                    chk(due_q[0] == cyc, "R4 latency", cyc, due_q[0]);
                    chk(longint'(out_data) == exp_q[0], tag_q[0], longint'(out_data), exp_q[0]);
                    void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
                end
            end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
                chk(0, "R4 missing out_valid", 0, 1);
                void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
            end
            if (in_valid && in_ready) begin
                for (int i = N - 1; i > 0; i--) hist[i] = hist[i - 1];
                hist[0] = longint'(in_data);
                exp_q.push_back(model());
                due_q.push_back(cyc + 1 + S);
                tag_q.push_back(tag);
            end
        end
    end

    // Offer one sample and return one tick after the accepting edge.
    task automatic send(input logic signed [DW-1:0] v);
        in_valid = 1; in_data = v;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        acc_cyc = cyc;
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic idle_reload();
        reload_req = 1; @(posedge clk); #1; reload_req = 0;
        @(negedge clk);
        while (!coef_ready) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic rand_coefs();
        for (int i = 0; i < N; i++) cmem[i] = CW'($urandom);
    endtask

    initial begin
        in_valid = 0; in_data = 0; reload_req = 0;
        void'($urandom(SEED));
        rand_coefs();
        tag = SYM ? "R7" : "R3";
        @(negedge clk);
        chk(!coef_ready && !in_ready && !out_valid, "R2 reset state", {coef_ready, in_ready, out_valid}, 0);
        while (!rst_n) @(negedge clk);
        while (!coef_ready) @(negedge clk);
        @(posedge clk); #1;
        // Impulse: outputs trace the coefficient set.
        send(1);
        for (int i = 0; i < N + 1; i++) send(0);
        // Random samples with random idle gaps.
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                for (int g = 0; g < int'($urandom_range(1, 5)); g++) begin @(posedge clk); #1; end
            end
            send(DW'($urandom));
        end
        // Back-to-back burst: accepts exactly S cycles apart (R5).
        for (int i = 0; i < 3 * N; i++) begin
            int prev_acc;
            prev_acc = acc_cyc;
            send(DW'($urandom));
            if (i > 0) chk(acc_cyc - prev_acc == S, "R5 accept spacing", acc_cyc - prev_acc, S);
        end
        // Reload requested in the middle of an output (R6), history kept (R8).
        rand_coefs();
        send(DW'($urandom));
        reload_req = 1; @(posedge clk); #1; reload_req = 0;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        chk(coef_ready && !coef_rd_en, "R6 load waits for output", {coef_ready, coef_rd_en}, 2);
        @(negedge clk);
        chk(coef_rd_en && !coef_ready && coef_addr == 0, "R6 load starts next cycle",
            {coef_rd_en, coef_ready}, 2);
        while (!coef_ready) @(negedge clk);
        @(posedge clk); #1;
        tag = "R8";
        for (int i = 0; i < N; i++) send(DW'($urandom));
        // Extremes: largest positive, then largest negative result (R9).
        tag = "R9";
        for (int i = 0; i < N; i++) cmem[i] = CW'(1 << (CW - 1));
        idle_reload();
        for (int i = 0; i < 2 * N; i++) send(DW'(1 << (DW - 1)));
        for (int i = 0; i < N; i++) cmem[i] = CW'((1 << (CW - 1)) - 1);
        idle_reload();
        for (int i = 0; i < 2 * N; i++) send(DW'(1 << (DW - 1)));
        // Random coefficients again, then random traffic.
        tag = SYM ? "R7" : "R3";
        rand_coefs();
        idle_reload();
        for (int i = 0; i < 30; i++) begin
            if ($urandom_range(0, 2) == 0) begin @(posedge clk); #1; end
            send(DW'($urandom));
        end
        for (int i = 0; i < 2 * N + 4; i++) @(posedge clk);
        chk(due_q.size() == 0, "R4 all outputs delivered", due_q.size(), 0);
        done = 1;
    end
endmodule

// Bench top: two filter configurations, a clock, reset and watchdog.
module sim_fir_serial_mac;
    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    fir_harness #(.N(8), .SYM(1'b0), .SEED(11)) h_lin (.clk(clk), .rst_n(rst_n));
    fir_harness #(.N(7), .SYM(1'b1), .SEED(23)) h_sym (.clk(clk), .rst_n(rst_n));

    initial begin
        int wd_chk;
        int wd_err;
        wd_chk = 0;
        wd_err = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        fork
            begin wait (h_lin.done && h_sym.done); end
            begin repeat (150000) @(posedge clk); end
        join_any
        if (!(h_lin.done && h_sym.done)) begin
            wd_chk = 1;
            wd_err = 1;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors",
                 h_lin.n_chk + h_sym.n_chk + wd_chk, h_lin.n_err + h_sym.n_err + wd_err);
        $finish;
    end
endmodule